// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides one unsigned N-bit integer by another over a fixed number of clock cycles and returns an N-bit quotient and an N-bit remainder. Its datapath has one divisor register, one subtractor, and one combined shift register. The upper part of the shift register holds the partial remainder. The lower part collects the quotient bits as they are produced. There is no separate quotient register.

An operation loads the dividend into the lower half and shifts the register left once. It then runs exactly N subtract-and-shift steps. Each step restores the partial remainder if the trial subtraction borrows, and shifts the step's quotient bit into the least significant position. A final cycle moves only the remainder half one place right, which undoes the one surplus shift. The trial subtraction is one bit wider than the operands, so the top remainder bit is never lost.

A user raises `start` for one cycle with both operands while `busy` is low. The results are then valid from the cycle in which `done` pulses. They stay valid until the next operation completes.

Top module: `rdiv_seq`

## Requirements
- R1: For a nonzero divisor, the results satisfy dividend = quotient × divisor + remainder with remainder < divisor. Example: with N = 4, 7 ÷ 2 gives quotient 3 and remainder 1.
- R2: `done` is high for exactly one cycle. That cycle comes N + 2 clock cycles after the cycle in which `start` was accepted. One cycle is for load and shift, N are iteration steps, and one is the correction.
- R3: `busy` goes high in the cycle after `start` is accepted. It stays high until the correction cycle has finished, and it is low in the cycle where `done` is high.
- R4: While `busy` is high, `start` and the operand inputs are ignored. The running operation's result and its completion cycle do not change, and no extra `done` pulse occurs.
- R5: A zero divisor completes in the normal N + 2 cycles and gives a quotient of all ones and a remainder equal to the dividend.
- R6: `quotient` and `remainder` change only in a cycle where `done` is high, and they hold their values between completions.
- R7: After a synchronous active-high reset, `busy` and `done` are 0 and `quotient` and `remainder` are 0.
- R8: Boundary operands give exact results. These cases are a dividend smaller than the divisor (quotient 0), a divisor with its top bit set, a divisor of one, and the all-ones dividend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation; accepted only while busy is low |
| dividend | input | W | Unsigned dividend, sampled with an accepted start |
| divisor | input | W | Unsigned divisor, sampled with an accepted start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Registered quotient |
| remainder | output | W | Registered remainder |

## Verification
Each result is due exactly N + 2 cycles after the cycle in which `start` was accepted, and `busy` is due one cycle after that acceptance. The driver records the cycle of each accepted start in the scoreboard next to the expected quotient and remainder. The monitor, which samples on the falling edge, compares both values and the elapsed cycle count when `done` appears. A `done` with nothing queued exposes a start that should have been ignored. The outputs are also compared against the last completed result in every cycle in between.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_STEP = 2'd1,
    PH_FIX  = 2'd2
  } rdiv_phase_e;
endpackage

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic do_load,
  output logic do_step,
  output logic do_fix,
  output logic busy
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  rdiv_phase_e phase;
  logic [CW-1:0] step_cnt;

  assign do_load = (phase == PH_IDLE) && start;
  assign do_step = (phase == PH_STEP);
  assign do_fix  = (phase == PH_FIX);
  assign busy    = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      step_cnt <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          step_cnt <= '0;
          if (start) phase <= PH_STEP;
        end
        PH_STEP: begin
          step_cnt <= step_cnt + 1'b1;
          if (step_cnt == LAST) phase <= PH_FIX;
        end
        PH_FIX:  phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdiv_datapath.sv
module rdiv_datapath #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         do_load,
  input  logic         do_step,
  input  logic         do_fix,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] dvs_hold,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int HW = W + 1;   // upper half keeps one spare bit
  localparam int DW = W + 2;   // trial difference with borrow bit

  logic [HW-1:0] part_hi;
  logic [W-1:0]  part_lo;
  logic [W-1:0]  dvs_r;
  logic [DW-1:0] trial;
  logic          borrow;
  logic [HW-1:0] kept_hi;

  assign trial   = {1'b0, part_hi} - {2'b00, dvs_r};
  assign borrow  = trial[DW-1];
  assign kept_hi = borrow ? part_hi : trial[HW-1:0];
  assign dvs_hold = dvs_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      part_hi <= '0;
      part_lo <= '0;
      dvs_r   <= '0;
    end else if (do_load) begin
      dvs_r <= divisor;
      {part_hi, part_lo} <= {{W{1'b0}}, dividend, 1'b0};
    end else if (do_step) begin
      {part_hi, part_lo} <= {kept_hi[W-1:0], part_lo, ~borrow};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      done <= do_fix;
      if (do_fix) begin
        quotient  <= part_lo;
        remainder <= part_hi[W:1];
      end
    end
  end
endmodule

// File: rtl/rdiv_seq.sv
module rdiv_seq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  logic         do_load;
  logic         do_step;
  logic         do_fix;
  logic [W-1:0] dvs_hold;

  rdiv_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .do_load (do_load),
    .do_step (do_step),
    .do_fix  (do_fix),
    .busy    (busy)
  );

  rdiv_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .do_load   (do_load),
    .do_step   (do_step),
    .do_fix    (do_fix),
    .dividend  (dividend),
    .divisor   (divisor),
    .dvs_hold  (dvs_hold),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder)
  );
endmodule

// File: rtl/rdiv_seq_chk.sv
module rdiv_seq_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic [W-1:0] dvs_hold
);
  localparam int CW = $clog2(W + 4);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)                run_cnt <= '0;
    else if (start && !busy) run_cnt <= CW'(1);
    else if (done)          run_cnt <= '0;
    else if (run_cnt != 0)  run_cnt <= run_cnt + 1'b1;
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst) done |-> (run_cnt == CW'(W + 2)));
  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
  // R3
  busy_done_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R1
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (done && dvs_hold != '0) |-> (remainder < dvs_hold));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |=> (!done -> ($stable(quotient) && $stable(remainder))));
endmodule

bind rdiv_seq rdiv_seq_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .quotient  (quotient),
  .remainder (remainder),
  .dvs_hold  (dvs_hold)
);

// File: tb/tb_rdiv_seq.sv
`timescale 1ns/1ps
module tb_rdiv_seq;
  localparam int W  = 32;
  localparam int WS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;

  logic         start = 1'b0;
  logic [W-1:0] dvd = '0, dvs = '0;
  logic         busy, done;
  logic [W-1:0] quo, rem;

  rdiv_seq #(.W(W)) dut (
    .clk(clk), .rst(rst), .start(start), .dividend(dvd), .divisor(dvs),
    .busy(busy), .done(done), .quotient(quo), .remainder(rem)
  );

  logic          s_start = 1'b0;
  logic [WS-1:0] s_dvd = '0, s_dvs = '0;
  logic          s_busy, s_done;
  logic [WS-1:0] s_quo, s_rem;

  rdiv_seq #(.W(WS)) dut_n4 (
    .clk(clk), .rst(rst), .start(s_start), .dividend(s_dvd), .divisor(s_dvs),
    .busy(s_busy), .done(s_done), .quotient(s_quo), .remainder(s_rem)
  );

  logic [W-1:0] exp_q[$];
  logic [W-1:0] exp_r[$];
  int           exp_c[$];
  string        exp_tag[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Driver: pushes the expected item into the scoreboard
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; dvd = a; dvs = b;
    exp_q.push_back(b == 0 ? '1 : a / b);
    exp_r.push_back(b == 0 ? a : a % b);
    exp_c.push_back(cyc);
    exp_tag.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R3", "busy after accept", busy, 1);
  endtask

  // Monitor: pops and compares when done appears
  logic [W-1:0] last_q = '0, last_r = '0;
  bit mon_on = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (done) begin
        check(busy == 1'b0, "R3", "busy low with done", busy, 0);
        if (exp_q.size() == 0) begin
          check(0, "R4", "unexpected done", 1, 0);
        end else begin
          automatic logic [W-1:0] eq = exp_q.pop_front();
          automatic logic [W-1:0] er = exp_r.pop_front();
          automatic int ec = exp_c.pop_front();
          automatic string tg = exp_tag.pop_front();
          check(quo == eq, tg, "quotient", quo, eq);
          check(rem == er, tg, "remainder", rem, er);
          check(cyc - ec == W + 2, "R2", "latency", cyc - ec, W + 2);
        end
        last_q = quo; last_r = rem;
      end else begin
        check(quo == last_q && rem == last_r, "R6", "hold between completions",
              quo, last_q);
      end
    end
  end

  // N = 4 direct run
  task automatic run_small(input logic [WS-1:0] a, input logic [WS-1:0] b);
    int c0, c1;
    logic [WS-1:0] eq, er;
    eq = (b == 0) ? '1 : a / b;
    er = (b == 0) ? a : a % b;
    @(negedge clk);
    s_start = 1'b1; s_dvd = a; s_dvs = b;
    c0 = cyc;
    @(negedge clk);
    s_start = 1'b0;
    while (!s_done) @(negedge clk);
    c1 = cyc;
    check(s_quo == eq, (b == 0) ? "R5" : "R1", "n4 quotient", s_quo, eq);
    check(s_rem == er, (b == 0) ? "R5" : "R1", "n4 remainder", s_rem, er);
    check(c1 - c0 == WS + 2, "R2", "n4 latency", c1 - c0, WS + 2);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", "timeout", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7
    check(!busy && !done, "R7", "busy/done after reset", {busy, done}, 0);
    check(quo == 0 && rem == 0, "R7", "results after reset", quo, 0);
    check(!s_busy && s_quo == 0 && s_rem == 0, "R7", "n4 after reset", s_quo, 0);
    mon_on = 1;

    // R8 and R1 small: the worked example
    run_small(4'd7, 4'd2);
    // R1 R5 R8 exhaustive small width
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run_small(WS'(a), WS'(b));

    issue(32'd100, 32'd7, "R1");
    issue(32'd3, 32'd9, "R8");
    issue(32'hFFFF_FFFF, 32'd1, "R8");
    issue(32'hFFFF_FFFF, 32'h8000_0001, "R8");
    issue(32'h8000_0000, 32'hFFFF_FFFF, "R8");
    issue(32'h1234_5678, 32'd0, "R5");
    issue(32'hDEAD_BEEF, 32'h0001_0003, "R1");
    for (int i = 0; i < 40; i++)
      issue(32'(i * 32'h9E37_79B9 + 7), 32'((i * 32'h0101_0203) >> (i % 31)), "R1");

    // R4: starts during busy must be ignored
    issue(32'd1000, 32'd33, "R4");
    repeat (5) begin
      start = 1'b1; dvd = 32'd5; dvs = 32'd1;
      @(negedge clk);
    end
    start = 1'b0;
    issue(32'd77, 32'd8, "R4");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (W + 6) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule